// File: doc/BRIEF.md
# Serial-Programmed Clock Select Register

This block drives a bank of ten 2:1 clock selectors from a word loaded over a three-wire serial port. A serial clock moves one bit per rising edge into a 10-bit shift register. A load strobe copies the shift register into a holding register, and the holding register supplies the select bit of each output. Output `n` carries clock input 0 when its held bit is 1. It carries clock input 1 when its held bit is 0.

The bit that leaves the low end of the shift register is driven on a serial output. Several blocks can therefore share one serial clock and one load strobe, with each block's serial output wired to the next block's serial input. A single pulse of the strobe then updates every block in the chain. After power-up the registers hold unknown values, so every block in the chain needs a full load before its outputs are used.

The three serial inputs are asynchronous. Each one passes through a synchronizer clocked by a fast system clock. A shift takes place on a detected rising edge of the synchronized serial clock. The holding register is written on every system cycle while the synchronized strobe is high. It therefore follows the shift register while the strobe is high and keeps its last value once the strobe falls. An optional synchronous reset clears both registers.

Top module: `clksel_serial_bank`

## Requirements
- R1: The shift register changes only on a system cycle that sees a rising edge of the synchronized serial clock. A serial clock held high, or changes on the serial data line alone, cause no further shift.
- R2: Each shift moves the register one place toward bit 0 and puts the sampled data bit into bit 9. After ten shifts the first bit sent sits in bit 0, and held bit `n` controls output `n`.
- R3: While the synchronized strobe is high, the holding register takes the shift register's value on every system cycle. Shifts made while the strobe stays high therefore reach the outputs.
- R4: While the synchronized strobe is low, the holding register keeps its value, and shifting changes no output.
- R5: Output `n` equals `ck0_in` when held bit `n` is 1, and equals `ck1_in` when held bit `n` is 0.
- R6: `ser_dout` always equals bit 0 of the shift register, which is the bit that leaves on the next shift.
- R7: With `SYNC_STAGES` = 2, a serial clock edge or strobe level seen at system edge k acts at system edge k+2. The prior-level flop of the edge detector supplies the third register.
- R8: With `HAS_RESET` = 1, `rst` clears the shift register, the holding register and the synchronizers. All outputs then carry `ck1_in` and `ser_dout` is 0.
- R9: In a chain of two blocks, 20 shifts followed by one strobe pulse load bits 0 to 9 into the far block and bits 10 to 19 into the near block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for synchronizing and for all registers |
| rst | input | 1 | Synchronous reset, active high (has no effect when HAS_RESET = 0) |
| ser_clk | input | 1 | Serial clock, asynchronous; a shift happens on each rising edge |
| ser_din | input | 1 | Serial data, sampled on each serial clock rising edge |
| ser_load | input | 1 | Load strobe: high lets the holding register follow, low keeps it |
| ck0_in | input | 1 | Clock input 0, routed where the held bit is 1 |
| ck1_in | input | 1 | Clock input 1, routed where the held bit is 0 |
| ser_dout | output | 1 | Cascade output, bit 0 of the shift register |
| clk_out | output | W | Selected clock for each output |

## Verification
A shift and a holding-register update can land in the same system cycle. This happens when a serial clock edge arrives while the strobe is still high. In that cycle the holding register must capture the value from before the shift, and it must pick up the shifted value one cycle later. The bench provokes this by holding the strobe high across several serial clock pulses. On every system cycle it compares both chained blocks against a behavioural model that keeps histories of the input levels as bit vectors. An assertion ties each holding-register value to the shift register value of the cycle before.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int DEF_WIDTH       = 10;
  localparam int DEF_SYNC_STAGES = 2;

  // Meaning of one held select bit
  typedef enum logic {
    PICK_CK1 = 1'b0,
    PICK_CK0 = 1'b1
  } pick_e;

  // Route one of the two clock inputs according to a select bit
  function automatic logic pick_clock(input logic sel, input logic ck0, input logic ck1);
    return (pick_e'(sel) == PICK_CK0) ? ck0 : ck1;
  endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/clksel_shifter.sv
module clksel_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] sr_q
);

  // New bit enters at the top, everything moves toward bit 0
  function automatic logic [W-1:0] push_top(input logic [W-1:0] cur, input logic b);
    return {b, cur[W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (step) sr_q <= push_top(sr_q, din);
  end

endmodule

// File: rtl/clksel_holder.sv
module clksel_holder #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_en,
  input  logic [W-1:0] src,
  output logic [W-1:0] held_q
);

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '0;
    else if (open_en) held_q <= src;
  end

endmodule

// File: rtl/clksel_muxbank.sv
module clksel_muxbank import clksel_pkg::*; #(
  parameter int W = 10
) (
  input  logic [W-1:0] sel,
  input  logic         ck0,
  input  logic         ck1,
  output logic [W-1:0] outs
);

  generate
    for (genvar n = 0; n < W; n++) begin : g_sel
      assign outs[n] = pick_clock(sel[n], ck0, ck1);
    end
  endgenerate

endmodule

// File: rtl/clksel_serial_bank.sv
module clksel_serial_bank import clksel_pkg::*; #(
  parameter int W           = DEF_WIDTH,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter bit HAS_RESET   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_din,
  input  logic         ser_load,
  input  logic         ck0_in,
  input  logic         ck1_in,
  output logic         ser_dout,
  output logic [W-1:0] clk_out
);

  localparam int NUM_SER = 3;
  localparam int IX_CLK  = 0;
  localparam int IX_DAT  = 1;
  localparam int IX_LD   = 2;

  logic               rst_eff;
  logic [NUM_SER-1:0] ser_raw;
  logic [NUM_SER-1:0] ser_s;
  logic               sclk_prev;
  logic               sclk_rise;    // event: synchronized serial clock rose
  logic               load_active;  // event: holding register open this cycle
  logic [W-1:0]       shreg;
  logic [W-1:0]       latch_q;

  assign rst_eff = HAS_RESET ? rst : 1'b0;
  assign ser_raw = {ser_load, ser_din, ser_clk};

  generate
    for (genvar i = 0; i < NUM_SER; i++) begin : g_sync
      clksel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst_eff),
        .d   (ser_raw[i]),
        .q   (ser_s[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_eff) sclk_prev <= 1'b0;
    else         sclk_prev <= ser_s[IX_CLK];
  end

  assign sclk_rise   = ser_s[IX_CLK] & ~sclk_prev;
  assign load_active = ser_s[IX_LD];

  clksel_shifter #(.W(W)) u_shift (
    .clk  (clk),
    .rst  (rst_eff),
    .step (sclk_rise),
    .din  (ser_s[IX_DAT]),
    .sr_q (shreg)
  );

  clksel_holder #(.W(W)) u_hold (
    .clk     (clk),
    .rst     (rst_eff),
    .open_en (load_active),
    .src     (shreg),
    .held_q  (latch_q)
  );

  clksel_muxbank #(.W(W)) u_mux (
    .sel  (latch_q),
    .ck0  (ck0_in),
    .ck1  (ck1_in),
    .outs (clk_out)
  );

  assign ser_dout = shreg[0];

endmodule

// File: rtl/clksel_serial_bank_chk.sv
module clksel_serial_bank_chk #(
  parameter int W         = 10,
  parameter bit HAS_RESET = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         sclk_rise,
  input logic         load_active,
  input logic [W-1:0] shreg,
  input logic [W-1:0] latch_q,
  input logic         ser_dout,
  input logic         ck0_in,
  input logic         ck1_in,
  input logic [W-1:0] clk_out
);

  a_r1_no_stray_shift: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(shreg));

  a_r6_dout_next: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> ser_dout == $past(shreg[1]));

  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    load_active |=> latch_q == $past(shreg));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !load_active |=> $stable(latch_q));

  a_r5_all_ck0: assert property (@(posedge clk) disable iff (rst)
    (&latch_q) |-> clk_out == {W{ck0_in}});

  a_r5_all_ck1: assert property (@(posedge clk) disable iff (rst)
    (~|latch_q) |-> clk_out == {W{ck1_in}});

  generate
    if (HAS_RESET) begin : g_rst
      a_r8_clear: assert property (@(posedge clk)
        rst |=> (shreg == '0 && latch_q == '0 && !ser_dout));
    end
  endgenerate

endmodule

bind clksel_serial_bank clksel_serial_bank_chk #(.W(W), .HAS_RESET(HAS_RESET)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sclk_rise   (sclk_rise),
  .load_active (load_active),
  .shreg       (shreg),
  .latch_q     (latch_q),
  .ser_dout    (ser_dout),
  .ck0_in      (ck0_in),
  .ck1_in      (ck1_in),
  .clk_out     (clk_out)
);

// File: tb/clksel_serial_bank_tb.sv
module clksel_serial_bank_tb;

  localparam int CLK_PERIOD = 8;
  localparam int W    = 10;
  localparam int SYNC = 2;
  localparam int CH   = 2 * W;

  logic clk = 1'b0;
  logic rst, s_clk, s_din, s_load, ck0, ck1;
  logic dout_a, dout_b;
  logic [W-1:0] out_a, out_b;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  // independent expectations
  logic [CH-1:0] ch;        // whole chain: [W-1:0] far block, [CH-1:W] near block
  logic [W-1:0]  exp_a, exp_b;

  // per-cycle behavioural model
  logic [SYNC+1:0] h_clk, h_da, h_db, h_ld;
  logic [W-1:0]    m_a, m_b, l_a, l_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksel_serial_bank #(.W(W), .SYNC_STAGES(SYNC), .HAS_RESET(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ser_clk(s_clk), .ser_din(s_din), .ser_load(s_load),
    .ck0_in(ck0), .ck1_in(ck1), .ser_dout(dout_a), .clk_out(out_a));

  clksel_serial_bank #(.W(W), .SYNC_STAGES(SYNC), .HAS_RESET(1'b1)) u_far (
    .clk(clk), .rst(rst), .ser_clk(s_clk), .ser_din(dout_a), .ser_load(s_load),
    .ck0_in(ck0), .ck1_in(ck1), .ser_dout(dout_b), .clk_out(out_b));

  function automatic logic [W-1:0] route(input logic [W-1:0] sel, input logic c0, input logic c1);
    logic [W-1:0] r;
    for (int n = 0; n < W; n++) r[n] = sel[n] ? c0 : c1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R7: cycle-accurate reference compared on every clock
  always @(posedge clk) begin
    if (rst) begin
      h_clk = '0; h_da = '0; h_db = '0; h_ld = '0;
      m_a = '0; m_b = '0; l_a = '0; l_b = '0;
    end else begin
      h_clk = {h_clk[SYNC:0], s_clk};
      h_da  = {h_da[SYNC:0], s_din};
      h_db  = {h_db[SYNC:0], m_a[0]};
      h_ld  = {h_ld[SYNC:0], s_load};
      if (h_ld[SYNC]) begin l_a = m_a; l_b = m_b; end
      if (h_clk[SYNC] && !h_clk[SYNC+1]) begin
        m_a = {h_da[SYNC], m_a[W-1:1]};
        m_b = {h_db[SYNC], m_b[W-1:1]};
      end
    end
    #2;
    if (!done) begin
      chk("R7 near outputs vs model", 32'(out_a), 32'(route(l_a, ck0, ck1)));
      chk("R7 far outputs vs model",  32'(out_b), 32'(route(l_b, ck0, ck1)));
      chk("R7 near dout vs model", 32'(dout_a), 32'(m_a[0]));
      chk("R7 far dout vs model",  32'(dout_b), 32'(m_b[0]));
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); s_din = b;
    wait_neg(2);    s_clk = 1'b1;
    wait_neg(4);    s_clk = 1'b0;
    wait_neg(4);
    ch = {b, ch[CH-1:1]};
  endtask

  task automatic pulse_load();
    @(negedge clk); s_load = 1'b1;
    wait_neg(4);    s_load = 1'b0;
    wait_neg(SYNC + 4);
    exp_a = ch[CH-1:W];
    exp_b = ch[W-1:0];
  endtask

  // R5: drive both clock polarities and compare every output
  task automatic check_outs(input string tag, input logic [W-1:0] ea, input logic [W-1:0] eb);
    for (int ph = 0; ph < 2; ph++) begin
      @(negedge clk);
      ck0 = (ph == 0);
      ck1 = (ph != 0);
      #1;
      chk({"R5 ", tag, " near"}, 32'(out_a), 32'(route(ea, ck0, ck1)));
      chk({"R5 ", tag, " far"},  32'(out_b), 32'(route(eb, ck0, ck1)));
    end
  endtask

  task automatic check_dout(input string tag);
    chk({"R6 ", tag, " near dout"}, 32'(dout_a), 32'(ch[W]));
    chk({"R6 ", tag, " far dout"},  32'(dout_b), 32'(ch[0]));
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [CH-1:0] pat;
    logic [W-1:0]  snap_a, snap_b;
    rst = 1'b1; s_clk = 0; s_din = 0; s_load = 0; ck0 = 0; ck1 = 0;
    ch = '0; exp_a = '0; exp_b = '0;
    wait_neg(5); rst = 1'b0; wait_neg(5);

    // R8: cleared state routes clock input 1 everywhere
    check_outs("R8 after reset", '0, '0);
    chk("R8 near dout after reset", 32'(dout_a), 32'(0));

    // preload unknown-looking content, then a full program (R9)
    for (int i = 0; i < CH; i++) shift_bit(1'($urandom_range(1)));
    pulse_load();
    check_outs("R9 preload junk", exp_a, exp_b);

    pat = 20'hA5C39;
    for (int i = 0; i < CH; i++) shift_bit(pat[i]);
    pulse_load();
    check_outs("R2 R9 pattern one", exp_a, exp_b);
    chk("R2 far output0 carries first bit", 32'(exp_b[0]), 32'(pat[0]));
    chk("R9 near holds bits 10..19", 32'(exp_a), 32'(pat[CH-1:W]));
    check_dout("after pattern one");

    // R4: shifting without strobe leaves outputs alone
    snap_a = exp_a; snap_b = exp_b;
    for (int i = 0; i < CH; i++) shift_bit(~pat[i]);
    check_outs("R4 shift without load", snap_a, snap_b);
    check_dout("after unloaded shift");

    // R1: data toggles alone and a long-high serial clock give one shift at most
    for (int i = 0; i < 12; i++) begin @(negedge clk); s_din = ~s_din; end
    wait_neg(4);
    check_dout("R1 data-only toggles");
    @(negedge clk); s_din = 1'b1;
    wait_neg(2); s_clk = 1'b1;
    wait_neg(3);
    for (int i = 0; i < 10; i++) begin @(negedge clk); s_din = ~s_din; end
    s_clk = 1'b0; wait_neg(4);
    ch = {1'b1, ch[CH-1:1]};
    check_dout("R1 long-high clock one shift");

    // R3: strobe held high, shifts reach the outputs
    @(negedge clk); s_load = 1'b1;
    wait_neg(SYNC + 3);
    check_outs("R3 open latch", ch[CH-1:W], ch[W-1:0]);
    shift_bit(1'b0);
    check_outs("R3 follows shift 1", ch[CH-1:W], ch[W-1:0]);
    shift_bit(1'b1);
    check_outs("R3 follows shift 2", ch[CH-1:W], ch[W-1:0]);
    @(negedge clk); s_load = 1'b0;
    wait_neg(SYNC + 3);
    snap_a = ch[CH-1:W]; snap_b = ch[W-1:0];
    shift_bit(1'b0);
    shift_bit(1'b1);
    check_outs("R4 frozen after strobe fall", snap_a, snap_b);

    // all-ones program: every output carries clock input 0 (R5)
    for (int i = 0; i < CH; i++) shift_bit(1'b1);
    pulse_load();
    check_outs("all ones", {W{1'b1}}, {W{1'b1}});

    // R8: reset mid-run
    @(negedge clk); rst = 1'b1;
    wait_neg(3); rst = 1'b0; ch = '0;
    wait_neg(3);
    check_outs("R8 mid-run reset", '0, '0);
    check_dout("R8 mid-run reset");

    wait_neg(4);
    finish_run();
  end

endmodule